// File: doc/BRIEF.md
# Serial Shift Unit Clock Selector

This block chooses the clock event that drives an 8-bit serial shift register and a 4-bit transfer counter, both modelled inside it. A 2-bit source field picks one of four schemes: software strobe, timer compare pulse, rising edge of an external serial clock, or falling edge of that clock. Two strobe bits sit beside the source field. The clock-strobe bit and the toggle-strobe bit take different roles depending on which source is selected.

With the software scheme, writing the clock-strobe bit as 1 moves the shift register one place and adds one to the counter. With the timer scheme, each compare pulse does both. With either external scheme, the shift register follows one edge of the synchronised pin. The counter then has two options. With a stored clock-strobe value of 0 it counts both pin edges. With a value of 1 it counts each write of the toggle-strobe bit, which lets a master see the end of a transfer before the last pin edge comes back. A toggle-strobe write always inverts the clock-port value that drives a master-mode clock pin.

All control travels over a single-cycle configuration write (`cfg_we` with its three fields). Every field of a write takes effect in the cycle of the write. This covers the strobe actions it carries, and those actions use the source and clock-strobe values in that same write. There is no stream interface, so there is no back-pressure. All pins are plain level or pulse signals.

Top module: `ser_clk_select`

## Requirements
- R1: After reset the stored source is 00, the stored clock-strobe value is 0, the clock-port value is 0, the counter is 0, the overflow flag is 0 and the shift register is 0.
- R2: A write with source 00 and clock-strobe 1 raises `shift_en` and `cnt_inc` during the write cycle, and the counter rises by one at the next clock edge. A write with source 00 and clock-strobe 0 raises neither, and the counter holds.
- R3: With source 01, `shift_en` and `cnt_inc` both equal `tmr_match`, whatever the clock-strobe value is. Toggle-strobe writes do not count.
- R4: With source 10 only rising pin edges raise `shift_en`, and with source 11 only falling pin edges do. The pulse is high in the cycle after the second clock edge that samples the new pin level, and the shift takes place on the third edge.
- R5: With source 10 or 11 and a stored clock-strobe value of 0, the counter increments once for every pin edge in either direction.
- R6: With source 10 or 11 and a clock-strobe value of 1, pin edges leave the counter alone. Each toggle-strobe write raises `cnt_inc` in its write cycle, and the counter rises by one at the following edge. The shift register still follows the selected pin edge.
- R7: Every write carrying toggle-strobe 1 inverts `clk_port` at that write's clock edge, in every source mode. No other event changes `clk_port`.
- R8: `ctrl_rd` is {stored source, 2'b00}. Source sits in bits [3:2], and both strobe positions [1:0] read as zero.
- R9: On each shift, `shift_q` moves toward the MSB at the clock edge that ends the shift cycle, and `data_out` (the MSB) changes at that same edge. The bit entering at bit 0 is the `data_in` level during the cycle before the shift cycle.
- R10: The counter wraps from 15 to 0. The wrap sets the sticky `ovf_flag`. A cycle with `ovf_clr` high clears the flag, except that a wrap in the same cycle wins.
- R11: Each pin transition produces at most one `shift_en` pulse, and that pulse lasts exactly one cycle.
- R12: Sources that are not selected have no effect. In mode 00, timer pulses and pin edges change neither the counter nor the shift register. In mode 01, pin edges change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write pulse |
| cfg_src | input | 2 | Source select written with `cfg_we` |
| cfg_stb | input | 1 | Clock-strobe bit written with `cfg_we` |
| cfg_tgl | input | 1 | Toggle-strobe bit written with `cfg_we` |
| tmr_match | input | 1 | Timer compare-match pulse |
| sclk_pin | input | 1 | External serial clock pin, asynchronous |
| data_in | input | 1 | Serial data input |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| ctrl_rd | output | 4 | Control readback {source, 2'b00} |
| shift_en | output | 1 | Shift-register clock pulse |
| cnt_inc | output | 1 | Counter increment pulse |
| clk_port | output | 1 | Toggled clock-port value |
| shift_q | output | 8 | Shift register contents |
| data_out | output | 1 | Serial data output (MSB) |
| cnt_q | output | 4 | Transfer counter |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
A wrong stored source or clock-strobe value shows up at `ctrl_rd` immediately. It also shows up at the first later event: a strobe write, a timer pulse or a pin edge then pulses the wrong output, or pulses nothing. Synchronizer faults appear as a pulse that comes one cycle early or late relative to the pin change, or as a pulse that repeats. A corrupt counter or clock-port value is visible at the next increment or toggle, and a bad wrap shows on the sixteenth increment.

// File: rtl/ser_clk_pkg.sv
package ser_clk_pkg;
  typedef enum logic [1:0] {
    SRC_SOFT    = 2'b00,
    SRC_TIMER   = 2'b01,
    SRC_EXT_POS = 2'b10,
    SRC_EXT_NEG = 2'b11
  } src_e;

  typedef struct packed {
    logic shift;
    logic count;
  } tick_t;
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  // synchronizer stages followed by one history flop
  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/ser_clk_route.sv
module ser_clk_route
  import ser_clk_pkg::*;
(
  input  src_e  src,
  input  logic  sel,
  input  logic  sw_stb,
  input  logic  tgl_stb,
  input  logic  tmr,
  input  logic  rise,
  input  logic  fall,
  output tick_t tick
);
  always_comb begin
    tick = '0;
    unique case (src)
      SRC_SOFT: begin
        tick.shift = sw_stb;
        tick.count = sw_stb;
      end
      SRC_TIMER: begin
        tick.shift = tmr;
        tick.count = tmr;
      end
      SRC_EXT_POS: begin
        tick.shift = rise;
        tick.count = sel ? tgl_stb : (rise | fall);
      end
      SRC_EXT_NEG: begin
        tick.shift = fall;
        tick.count = sel ? tgl_stb : (rise | fall);
      end
      default: tick = '0;
    endcase
  end
endmodule

// File: rtl/ser_shift_cnt.sv
module ser_shift_cnt #(
  parameter int SHIFT_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift,
  input  logic               count,
  input  logic               din,
  input  logic               ovf_clr,
  output logic [SHIFT_W-1:0] shift_q,
  output logic               data_out,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic din_q;
  logic wrap;

  // the bit that enters is the level seen one cycle before the shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shift_q <= '0;
    else if (shift) shift_q <= {shift_q[SHIFT_W-2:0], din_q};
  end

  assign wrap = count && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (count) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (wrap)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  assign data_out = shift_q[SHIFT_W-1];
endmodule

// File: rtl/ser_clk_select.sv
module ser_clk_select
  import ser_clk_pkg::*;
#(
  parameter int SHIFT_W     = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_src,
  input  logic               cfg_stb,
  input  logic               cfg_tgl,
  input  logic               tmr_match,
  input  logic               sclk_pin,
  input  logic               data_in,
  input  logic               ovf_clr,
  output logic [3:0]         ctrl_rd,
  output logic               shift_en,
  output logic               cnt_inc,
  output logic               clk_port,
  output logic [SHIFT_W-1:0] shift_q,
  output logic               data_out,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf_flag
);
  src_e  src_q, src_eff;
  logic  sel_q, sel_eff;
  logic  port_q;
  logic  sw_stb, tgl_stb;
  logic  pin_rise, pin_fall;
  tick_t tick;

  // stored control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_SOFT;
      sel_q <= 1'b0;
    end else if (cfg_we) begin
      src_q <= src_e'(cfg_src);
      sel_q <= cfg_stb;
    end
  end

  // a write acts with the fields it carries
  assign src_eff = cfg_we ? src_e'(cfg_src) : src_q;
  assign sel_eff = cfg_we ? cfg_stb : sel_q;
  assign sw_stb  = cfg_we && cfg_stb && (src_e'(cfg_src) == SRC_SOFT);
  assign tgl_stb = cfg_we && cfg_tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= 1'b0;
    else if (tgl_stb) port_q <= ~port_q;
  end

  ser_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (sclk_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  ser_clk_route i_route (
    .src    (src_eff),
    .sel    (sel_eff),
    .sw_stb (sw_stb),
    .tgl_stb(tgl_stb),
    .tmr    (tmr_match),
    .rise   (pin_rise),
    .fall   (pin_fall),
    .tick   (tick)
  );

  ser_shift_cnt #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) i_sc (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (tick.shift),
    .count   (tick.count),
    .din     (data_in),
    .ovf_clr (ovf_clr),
    .shift_q (shift_q),
    .data_out(data_out),
    .cnt_q   (cnt_q),
    .ovf     (ovf_flag)
  );

  assign ctrl_rd  = {src_q, 2'b00};
  assign shift_en = tick.shift;
  assign cnt_inc  = tick.count;
  assign clk_port = port_q;
endmodule

// File: rtl/ser_clk_select_chk.sv
module ser_clk_select_chk #(
  parameter int SHIFT_W = 8,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [1:0]         cfg_src,
  input logic               cfg_stb,
  input logic               cfg_tgl,
  input logic               tmr_match,
  input logic [3:0]         ctrl_rd,
  input logic               shift_en,
  input logic               cnt_inc,
  input logic               clk_port,
  input logic [SHIFT_W-1:0] shift_q,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               ovf_flag
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_SOFT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_src == 2'b00 && cfg_stb) |-> (shift_en && cnt_inc)); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_inc |=> $stable(cnt_q)); // R2

  AST_TIMER_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && ctrl_rd[3:2] == 2'b01) |-> (shift_en == tmr_match && cnt_inc == tmr_match)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && cnt_q == CMAX) |=> (cnt_q == '0 && ovf_flag)); // R10

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_tgl) |=> (clk_port != $past(clk_port))); // R7

  AST_PORT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_tgl) |=> $stable(clk_port)); // R7

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (shift_q[SHIFT_W-1:1] == $past(shift_q[SHIFT_W-2:0]))); // R9

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shift_q)); // R12
endmodule

bind ser_clk_select ser_clk_select_chk #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_src  (cfg_src),
  .cfg_stb  (cfg_stb),
  .cfg_tgl  (cfg_tgl),
  .tmr_match(tmr_match),
  .ctrl_rd  (ctrl_rd),
  .shift_en (shift_en),
  .cnt_inc  (cnt_inc),
  .clk_port (clk_port),
  .shift_q  (shift_q),
  .cnt_q    (cnt_q),
  .ovf_flag (ovf_flag)
);

// File: tb/test_ser_clk_select.sv
module test_ser_clk_select;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic       cfg_stb = 1'b0;
  logic       cfg_tgl = 1'b0;
  logic       tmr_match = 1'b0;
  logic       sclk_pin = 1'b0;
  logic       data_in = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [3:0] ctrl_rd;
  logic       shift_en, cnt_inc, clk_port, data_out, ovf_flag;
  logic [7:0] shift_q;
  logic [3:0] cnt_q;

  int n_cmp = 0;
  int n_mis = 0;
  logic last_se, last_ci;
  logic exp_port = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_clk_select i_ser_clk_select (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_stb(cfg_stb), .cfg_tgl(cfg_tgl), .tmr_match(tmr_match),
    .sclk_pin(sclk_pin), .data_in(data_in), .ovf_clr(ovf_clr),
    .ctrl_rd(ctrl_rd), .shift_en(shift_en), .cnt_inc(cnt_inc),
    .clk_port(clk_port), .shift_q(shift_q), .data_out(data_out),
    .cnt_q(cnt_q), .ovf_flag(ovf_flag)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle configuration write; pulses sampled inside the write cycle
  task automatic wr(logic [1:0] s, logic b, logic t);
    @(negedge clk);
    cfg_we = 1'b1; cfg_src = s; cfg_stb = b; cfg_tgl = t;
    #1 last_se = shift_en; last_ci = cnt_inc;
    if (t) exp_port = ~exp_port;
    @(negedge clk);
    cfg_we = 1'b0; cfg_stb = 1'b0; cfg_tgl = 1'b0;
  endtask

  // drive a pin level and check the pulse window and its single width
  task automatic pin_to(logic v, logic exp_se, logic exp_ci, string req);
    logic [3:0] c0;
    c0 = cnt_q;
    @(negedge clk) sclk_pin = v;
    @(negedge clk);
    #1 chk({req, " no early pulse"}, {shift_en, cnt_inc}, 2'b00);
    @(negedge clk);
    #1 chk({req, " shift pulse"}, shift_en, exp_se);
    chk({req, " count pulse"}, cnt_inc, exp_ci);
    chk({req, " count before edge"}, cnt_q, c0);
    @(negedge clk);
    #1 chk({"R11 ", req, " single pulse"}, {shift_en, cnt_inc}, 2'b00);
    chk({req, " count after edge"}, cnt_q, c0 + exp_ci);
  endtask

  task automatic t_reset;
    chk("R1 count", cnt_q, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 port", clk_port, 0);
    chk("R1 ctrl", ctrl_rd, 0);
    chk("R1 shift", shift_q, 0);
  endtask

  task automatic t_soft;
    logic [3:0] c0;
    c0 = cnt_q;
    wr(2'b00, 1'b0, 1'b0);
    chk("R2 no strobe pulse", {last_se, last_ci}, 2'b00);
    chk("R2 no strobe count", cnt_q, c0);
    for (int i = 1; i <= 3; i++) begin
      wr(2'b00, 1'b1, 1'b0);
      chk("R2 strobe pulse", {last_se, last_ci}, 2'b11);
      chk("R2 strobe count", cnt_q, c0 + i);
    end
  endtask

  task automatic t_shift_timing;
    logic [7:0] pat = 8'b1011_0010;
    logic [7:0] exp_sh = '0;
    data_in = 1'b0;
    for (int i = 0; i < 8; i++) wr(2'b00, 1'b1, 1'b0);
    chk("R9 cleared", shift_q, 0);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) data_in = pat[i];
      @(negedge clk);
      data_in = ~pat[i];
      cfg_we = 1'b1; cfg_src = 2'b00; cfg_stb = 1'b1;
      #1 chk("R9 unchanged before edge", shift_q, exp_sh);
      @(negedge clk);
      cfg_we = 1'b0; cfg_stb = 1'b0;
      exp_sh = {exp_sh[6:0], pat[i]};
      chk("R9 shifted", shift_q, exp_sh);
      chk("R9 data_out", data_out, exp_sh[7]);
    end
  endtask

  task automatic t_timer;
    logic [3:0] c0;
    for (int b = 0; b < 2; b++) begin
      wr(2'b01, b[0], 1'b0);
      chk("R3 write no pulse", {last_se, last_ci}, 2'b00);
      c0 = cnt_q;
      @(negedge clk) tmr_match = 1'b1;
      #1 chk("R3 timer pulse", {shift_en, cnt_inc}, 2'b11);
      @(negedge clk) tmr_match = 1'b0;
      #1 chk("R3 timer count", cnt_q, c0 + 1);
      chk("R3 pulse gone", {shift_en, cnt_inc}, 2'b00);
    end
    c0 = cnt_q;
    wr(2'b01, 1'b1, 1'b1);
    chk("R3 toggle not counted", cnt_q, c0);
  endtask

  task automatic t_ext_edges;
    wr(2'b10, 1'b0, 1'b0);
    pin_to(1'b1, 1'b1, 1'b1, "R4 R5 pos mode rise");
    pin_to(1'b0, 1'b0, 1'b1, "R4 R5 pos mode fall");
    wr(2'b11, 1'b0, 1'b0);
    pin_to(1'b1, 1'b0, 1'b1, "R4 R5 neg mode rise");
    pin_to(1'b0, 1'b1, 1'b1, "R4 R5 neg mode fall");
  endtask

  task automatic t_toggle_count;
    logic [3:0] c0;
    wr(2'b10, 1'b1, 1'b0);
    pin_to(1'b1, 1'b1, 1'b0, "R6 rise shifts only");
    pin_to(1'b0, 1'b0, 1'b0, "R6 fall ignored");
    for (int i = 0; i < 2; i++) begin
      c0 = cnt_q;
      wr(2'b11, 1'b1, 1'b1);
      chk("R6 toggle pulse", {last_se, last_ci}, 2'b01);
      chk("R6 toggle count", cnt_q, c0 + 1);
      chk("R6 port follows", clk_port, exp_port);
    end
  endtask

  task automatic t_port;
    logic [1:0] m;
    for (int i = 0; i < 4; i++) begin
      m = 2'(i);
      wr(m, 1'b0, 1'b1);
      chk("R7 toggle", clk_port, exp_port);
      wr(m, 1'b0, 1'b0);
      chk("R7 no toggle", clk_port, exp_port);
    end
  endtask

  task automatic t_readback;
    wr(2'b10, 1'b1, 1'b1);
    chk("R8 readback ext sel", ctrl_rd, 4'b1000);
    wr(2'b11, 1'b0, 1'b0);
    chk("R8 readback neg", ctrl_rd, 4'b1100);
    wr(2'b01, 1'b1, 1'b0);
    chk("R8 readback timer", ctrl_rd, 4'b0100);
  endtask

  task automatic t_wrap;
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R10 flag cleared", ovf_flag, 0);
    for (int i = 0; i < 16 && cnt_q != 4'hF; i++) wr(2'b00, 1'b1, 1'b0);
    chk("R10 at max", cnt_q, 4'hF);
    chk("R10 no flag yet", ovf_flag, 0);
    wr(2'b00, 1'b1, 1'b0);
    chk("R10 wrapped", cnt_q, 0);
    chk("R10 flag set", ovf_flag, 1);
    wr(2'b00, 1'b1, 1'b0);
    chk("R10 flag sticky", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R10 flag clear", ovf_flag, 0);
  endtask

  task automatic t_ignore;
    logic [3:0] c0;
    logic [7:0] s0;
    wr(2'b00, 1'b0, 1'b0);
    c0 = cnt_q; s0 = shift_q;
    @(negedge clk) tmr_match = 1'b1;
    @(negedge clk) tmr_match = 1'b0;
    pin_to(1'b1, 1'b0, 1'b0, "R12 soft mode pin");
    pin_to(1'b0, 1'b0, 1'b0, "R12 soft mode pin");
    chk("R12 soft count", cnt_q, c0);
    chk("R12 soft shift", shift_q, s0);
    wr(2'b01, 1'b0, 1'b0);
    pin_to(1'b1, 1'b0, 1'b0, "R12 timer mode pin");
    pin_to(1'b0, 1'b0, 1'b0, "R12 timer mode pin");
    chk("R12 timer count", cnt_q, c0);
    chk("R12 timer shift", shift_q, s0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_soft;
    t_shift_timing;
    t_timer;
    t_ext_edges;
    t_toggle_count;
    t_port;
    t_readback;
    t_wrap;
    t_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule